// File: doc/BRIEF.md
# Vertical Slot-Shared Layer Bus

This block is the vertical link of a stacked chip. It is one shared bus that joins one node on every layer, plus the single arbiter that controls it. A flit placed on the bus by any layer reaches its destination layer in the same cycle, with no hops in between. Bus time is cut into frames. A frame holds exactly one slot for each layer that was asking for the bus when the frame began. Layers that are silent get no slot, so the frame grows and shrinks as demand changes.

Each layer has its own slot shift register. The arbiter loads it with a one-hot pattern at every frame boundary, and the register's low bit enables that layer's bus driver. The bus is modelled as a multiplexer over the enabled driver.

Each transmit side is a valid/ready stream. `tx_ready` is the layer's driver enable, and a flit moves when `tx_valid` and `tx_ready` are both high. A layer with ready low must hold its valid, data and destination. Receivers cannot apply back-pressure, so every layer must accept a flit in the cycle its `rx_valid` is high.

Top module: `vlayer_bus`

## Requirements
- R1: A flit accepted from layer s (tx_valid[s] and tx_ready[s] both high) with destination d appears in the same cycle as rx_valid[d] high, with rx_data equal to that flit. Any d in 0..N-1 is legal, including d equal to s.
- R2: A frame boundary is any cycle in which zero or one slots remain in the current frame. The frame that follows it has as many slots as there were layers with tx_valid high in that boundary cycle. Only those layers ever see tx_ready high in that frame.
- R3: At most one tx_ready bit is high in any cycle.
- R4: While no frame is in progress and no layer requests, every tx_ready and every rx_valid stays low.
- R5: Slot order within a frame starts at a rotating pointer and ascends through layer indices, wrapping at N. The pointer is 0 after reset and advances by one each time a non-empty frame is loaded. The first slot of a frame is in the cycle after its boundary.
- R6: Every layer that requests in a boundary cycle receives exactly one slot in the following frame, whether or not it still has data when that slot arrives.
- R7: A layer whose slot arrives while its tx_valid is low moves no flit, and all rx_valid bits stay low in that cycle.
- R8: Only the destination layer's rx_valid is high during a transfer.
- R9: During and right after reset, no tx_ready and no rx_valid is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | N | Per-layer request / flit valid |
| tx_ready | output | N | Per-layer driver enable (slot grant) |
| tx_data | input | N*W | Per-layer flit, layer i in bits [i*W +: W] |
| tx_dest | input | N*LW | Per-layer destination layer, layer i in bits [i*LW +: LW] |
| rx_valid | output | N | Per-layer received-flit strobe |
| rx_data | output | W | Flit on the bus, common to all receivers |

## Verification
The bench builds the bus with four layers and 128-bit flits. With four layers the rotating pointer wraps inside a short run, and frames of every length from one to four slots can be reached. That size also allows all layers to send at once with mixed destinations, including transfers back to the sender. Gaps in one layer's valid create slots that go unused, and quiet periods return the bus to idle between bursts.

// File: rtl/vlayer_bus_pkg.sv
package vlayer_bus_pkg;
  // Distance from base to idx walking upward around a ring of n layers.
  function automatic int ring_dist(input int idx, input int base, input int n);
    return (idx - base + n) % n;
  endfunction
endpackage

// File: rtl/vlayer_slot_lane.sv
module vlayer_slot_lane #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         req_i,
  input  logic [N-1:0] pat_i,
  output logic         en_o
);
  logic [N-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else if (load_i) sr_q <= pat_i;
    else sr_q <= sr_q >> 1;
  end

  assign en_o = sr_q[0];

  // A slot owed since the last boundary must be served before the next one.
  logic owed_q;
  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= 1'b0;
    else if (load_i) owed_q <= req_i;
    else if (en_o) owed_q <= 1'b0;
  end

  p_slot_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !en_o) |-> !owed_q);
  p_no_slot_unasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !req_i) |=> !en_o);
endmodule

// File: rtl/vlayer_frame_arb.sv
module vlayer_frame_arb #(
  parameter int N  = 4,
  parameter int LW = (N > 1) ? $clog2(N) : 1,
  parameter int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req_i,
  output logic           load_o,
  output logic [N*N-1:0] pat_o
);
  import vlayer_bus_pkg::*;

  logic [CW-1:0] left_q;
  logic [LW-1:0] ptr_q;
  logic          boundary;

  assign boundary = (left_q <= CW'(1));
  assign load_o   = boundary;

  // Slot position of each requester: requesters ahead of it in rotated order.
  always_comb begin
    pat_o = '0;
    for (int l = 0; l < N; l++) begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < N; j++) begin
        if (req_i[j] && (ring_dist(j, int'(ptr_q), N) < ring_dist(l, int'(ptr_q), N)))
          cnt++;
      end
      if (req_i[l]) pat_o[l*N +: N] = N'(1) << cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      ptr_q  <= '0;
    end else if (boundary) begin
      left_q <= CW'($countones(req_i));
      if (|req_i) ptr_q <= (ptr_q == LW'(N - 1)) ? '0 : ptr_q + 1'b1;
    end else begin
      left_q <= left_q - 1'b1;
    end
  end

  p_ptr_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && (|req_i)) |=> (ptr_q != $past(ptr_q)));
  p_ptr_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !(|req_i)) |=> $stable(ptr_q));
endmodule

// File: rtl/vlayer_xfer.sv
module vlayer_xfer #(
  parameter int N  = 4,
  parameter int W  = 128,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    en_i,
  input  logic [N-1:0]    tx_valid_i,
  input  logic [N*W-1:0]  tx_data_i,
  input  logic [N*LW-1:0] tx_dest_i,
  output logic [N-1:0]    rx_valid_o,
  output logic [W-1:0]    rx_data_o
);
  logic [LW-1:0] dest;
  logic          fire;

  always_comb begin
    rx_data_o = '0;
    dest      = '0;
    fire      = 1'b0;
    for (int l = 0; l < N; l++) begin
      if (en_i[l]) begin
        rx_data_o = tx_data_i[l*W +: W];
        dest      = tx_dest_i[l*LW +: LW];
        fire      = tx_valid_i[l];
      end
    end
    rx_valid_o = '0;
    for (int l = 0; l < N; l++)
      if (fire && (dest == LW'(l))) rx_valid_o[l] = 1'b1;
  end

  always_comb begin
    a_single_receiver_r8: assert ($onehot0(rx_valid_o));
  end
endmodule

// File: rtl/vlayer_bus.sv
module vlayer_bus #(
  parameter int N  = 4,
  parameter int W  = 128,
  parameter int LW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     tx_valid,
  output logic [N-1:0]     tx_ready,
  input  logic [N*W-1:0]   tx_data,
  input  logic [N*LW-1:0]  tx_dest,
  output logic [N-1:0]     rx_valid,
  output logic [W-1:0]     rx_data
);
  logic           load;
  logic [N*N-1:0] pat;
  logic [N-1:0]   en;

  vlayer_frame_arb #(.N(N), .LW(LW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_i(tx_valid), .load_o(load), .pat_o(pat)
  );

  for (genvar l = 0; l < N; l++) begin : g_lane
    vlayer_slot_lane #(.N(N)) u_lane (
      .clk(clk), .rst_n(rst_n), .load_i(load), .req_i(tx_valid[l]),
      .pat_i(pat[l*N +: N]), .en_o(en[l])
    );
  end

  assign tx_ready = en;

  vlayer_xfer #(.N(N), .W(W), .LW(LW)) u_xfer (
    .en_i(en), .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_dest_i(tx_dest),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );

  p_one_driver_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_ready));
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !(|tx_valid)) |=> !(|tx_ready));
  p_rx_needs_handshake_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |-> (|(tx_valid & tx_ready)));
  p_empty_slot_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(tx_valid & tx_ready)) |-> !(|rx_valid));
endmodule

// File: tb/sim_vlayer_bus.sv
module sim_vlayer_bus;
  localparam int N = 4, W = 128, LW = 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] tx_valid = '0;
  logic [N-1:0] tx_ready, rx_valid;
  logic [N*W-1:0] tx_data = '0;
  logic [N*LW-1:0] tx_dest = '0;
  logic [W-1:0] rx_data;

  always #2.5 clk = ~clk;

  vlayer_bus #(.N(N), .W(W), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_dest(tx_dest), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] sq_d[N][$];
  int           sq_t[N][$];
  logic [W-1:0] eq_d[$];
  int           eq_t[$];
  bit           hold[N];
  bit           toggle1 = 0;

  int m_left = 0, m_cur = 0, m_ptr = 0;
  int m_slot[N];
  logic [N-1:0] s_req, s_hs;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive();
    for (int l = 0; l < N; l++) begin
      bit v;
      v = (sq_d[l].size() > 0) && !hold[l];
      tx_valid[l] = v;
      tx_data[l*W +: W] = v ? sq_d[l][0] : '0;
      tx_dest[l*LW +: LW] = v ? LW'(sq_t[l][0]) : '0;
    end
  endtask

  task automatic push(input int src, input int dst, input int seq);
    sq_d[src].push_back({32'(src), 32'(dst), 32'(seq), 32'hC0DE_0000 + 32'(seq)});
    sq_t[src].push_back(dst);
  endtask

  task automatic step();
    logic [N-1:0] exp_rdy;
    @(negedge clk);
    exp_rdy = '0;
    for (int l = 0; l < N; l++)
      exp_rdy[l] = (m_left > 0) && (m_slot[l] == m_cur);
    // R2 R3 R5 R6: grant pattern follows the frame/rotation rules
    check(tx_ready == exp_rdy, "R5", "tx_ready", W'(tx_ready), W'(exp_rdy));
    s_hs = tx_valid & exp_rdy;
    s_req = tx_valid;
    for (int l = 0; l < N; l++)
      if (s_hs[l]) begin
        eq_d.push_back(sq_d[l][0]);
        eq_t.push_back(sq_t[l][0]);
      end
    // monitor
    if (eq_d.size() > 0) begin
      logic [W-1:0] ed; int et;
      ed = eq_d.pop_front(); et = eq_t.pop_front();
      check(rx_valid == (N'(1) << et), "R8", "rx_valid", W'(rx_valid), W'(N'(1) << et));
      check(rx_data == ed, "R1", "rx_data", rx_data, ed);
    end else begin
      // R7: no handshake, no delivery
      check(rx_valid == '0, "R7", "rx_valid idle", W'(rx_valid), '0);
    end
    @(posedge clk);
    #1;
    for (int l = 0; l < N; l++)
      if (s_hs[l]) begin
        void'(sq_d[l].pop_front());
        void'(sq_t[l].pop_front());
      end
    if (m_left <= 1) begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < N; k++) begin
        int l;
        l = (m_ptr + k) % N;
        if (s_req[l]) begin m_slot[l] = cnt; cnt++; end
        else m_slot[l] = -1;
      end
      m_left = cnt; m_cur = 0;
      if (cnt > 0) m_ptr = (m_ptr + 1) % N;
    end else begin
      m_left--; m_cur++;
    end
    if (toggle1) hold[1] = !hold[1];
    drive();
  endtask

  task automatic run_until_empty(input int cap);
    for (int i = 0; i < cap; i++) begin
      bit busy;
      busy = 0;
      for (int l = 0; l < N; l++) if (sq_d[l].size() > 0) busy = 1;
      if (!busy) break;
      step();
    end
  endtask

  initial begin
    for (int l = 0; l < N; l++) begin hold[l] = 0; m_slot[l] = -1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: quiet during reset
    check(tx_ready == '0, "R9", "tx_ready in reset", W'(tx_ready), '0);
    check(rx_valid == '0, "R9", "rx_valid in reset", W'(rx_valid), '0);
    @(posedge clk); #1;
    rst_n = 1;
    step(); step();
    // R4: idle after reset
    check(tx_ready == '0, "R4", "tx_ready idle", W'(tx_ready), '0);

    // single layer stream, 2 -> 0
    for (int i = 0; i < 3; i++) push(2, 0, i);
    drive();
    run_until_empty(50);
    repeat (4) step();

    // all layers at once, mixed destinations including self
    for (int i = 0; i < 4; i++)
      for (int l = 0; l < N; l++) push(l, (l + i) % N, 100 + i);
    drive();
    run_until_empty(200);
    repeat (5) step();

    // two layers, layer 1 with gaps creating empty slots (R7)
    toggle1 = 1;
    for (int i = 0; i < 5; i++) begin push(1, 3, 200 + i); push(3, 1, 300 + i); end
    drive();
    run_until_empty(300);
    toggle1 = 0; hold[1] = 0;
    repeat (6) step();

    // R4: quiet bus after bursts
    for (int i = 0; i < 8; i++) begin
      step();
      check(tx_ready == '0 && rx_valid == '0, "R4", "bus idle",
            W'({tx_ready, rx_valid}), '0);
    end

    // three layers, uneven lengths; frame shrinks as layers drain (R2 R6)
    for (int i = 0; i < 6; i++) push(0, 2, 400 + i);
    for (int i = 0; i < 2; i++) push(1, 1, 500 + i);
    for (int i = 0; i < 4; i++) push(3, 0, 600 + i);
    drive();
    run_until_empty(300);
    repeat (6) step();
    check(eq_d.size() == 0, "R1", "scoreboard drained", W'(eq_d.size()), '0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule